// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the device side of a parallel flash and builds the byte that a host reads back while an internal program or erase runs. When an operation is launched, the read path stops returning array contents and returns a status byte instead. Bit 6 of that byte inverts on every status read, so a host that reads twice can tell whether work is still in progress. Bit 5 reports a failure: it rises once the internal pulse count goes past a set limit without a successful verify.

The programming physics are reduced to one abstract verify per pulse. A program pulse verifies only if the pass input is high and the target byte needs no bit raised from 0 to 1. An erase pulse verifies whenever the pass input is high. Program can only clear bits, so a target with a 1 over a stored 0 never verifies. Such an operation always ends in the failure state.

A successful verify returns the block to array reads at once, so the toggling stops. A failed operation keeps toggling bit 6 and holds bit 5 high until a reset command arrives.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is in array mode: `status_mode_o` is 0 and `dout_o` equals `array_i`.
- R2: In array mode `dout_o` follows `array_i` and read strobes change nothing. A `start_i` pulse makes `status_mode_o` 1 from the next cycle, with a status byte of 8'h00 (bit 6 = toggle = 0, bit 5 = fail = 0, all other bits 0).
- R3: In status mode each cycle with `rd_i` high inverts bit 6 of `dout_o` from the next cycle. Cycles without `rd_i` leave it unchanged.
- R4: A `tick_i` cycle whose pulse verifies ends the operation. From the next cycle `status_mode_o` is 0, `dout_o` equals `array_i`, and reads no longer toggle. Verify means `pass_i` = 1, and for program (`op_kind_i` = 0) also (target AND NOT stored) = 0. For erase (`op_kind_i` = 1) `pass_i` = 1 alone is enough.
- R5: Failing ticks are counted from 0 at each start. After PULSE_LIMIT failing ticks bit 5 is still 0. The failing tick numbered PULSE_LIMIT+1 sets bit 5 to 1 from the next cycle.
- R6: A program whose target has a 1 in a position where the stored byte has 0 never verifies, even with `pass_i` = 1, and ends with bit 5 = 1.
- R7: In the failure state bit 5 stays 1, bit 6 keeps inverting on each read, and ticks are ignored. Only `rst_cmd_i` leaves this state, restoring array mode from the next cycle.
- R8: `rst_cmd_i` is ignored while an operation is still running and has not failed. `start_i` is ignored in status mode.
- R9: Each new operation starts with the toggle bit at 0 and the pulse count at 0, whatever earlier operations left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch an embedded operation (one-cycle strobe) |
| op_kind_i | input | 1 | 0 = program, 1 = erase; sampled with `start_i` |
| target_i | input | 8 | Byte to program; sampled with `start_i` |
| stored_i | input | 8 | Byte currently held at the location; sampled with `start_i` |
| tick_i | input | 1 | One internal program/erase pulse has finished |
| pass_i | input | 1 | Abstract physical verify result of that pulse |
| rd_i | input | 1 | Host read cycle |
| rst_cmd_i | input | 1 | Reset command decoded |
| array_i | input | 8 | Array data for the current read address |
| dout_o | output | 8 | Byte returned to the host |
| status_mode_o | output | 1 | 1 while status bytes are returned instead of array data |

## Verification
The bench builds the block with PULSE_LIMIT = 3 in place of the default 16. With that value the boundary between the third and fourth failing tick can be checked in a few cycles. The stalled one-over-zero program also reaches its failure quickly. The smaller limit keeps the counter narrow as well, so a wrap or off-by-one error at the limit shows up in the bit 5 checks.

// File: rtl/flsts_pkg.sv
package flsts_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned TOGGLE_BIT = 6;
  localparam int unsigned FAIL_BIT   = 5;

  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FAIL  = 2'd2
  } flsts_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } flsts_op_e;

  // A program can only clear bits: any 1 wanted over a stored 0 blocks it.
  function automatic logic prog_blocked(input logic [DATA_W-1:0] tgt,
                                        input logic [DATA_W-1:0] stored);
    return |(tgt & ~stored);
  endfunction

  function automatic logic pulse_verified(input flsts_op_e op,
                                          input logic [DATA_W-1:0] tgt,
                                          input logic [DATA_W-1:0] stored,
                                          input logic pass);
    return pass && !((op == OP_PROGRAM) && prog_blocked(tgt, stored));
  endfunction

  function automatic logic [DATA_W-1:0] status_byte(input logic tog,
                                                    input logic fail);
    logic [DATA_W-1:0] b;
    b = '0;
    b[TOGGLE_BIT] = tog;
    b[FAIL_BIT]   = fail;
    return b;
  endfunction

endpackage

// File: rtl/flsts_pulse_ctr.sv
module flsts_pulse_ctr #(
  parameter int unsigned PULSE_LIMIT = 16,
  localparam int unsigned CNT_W = $clog2(PULSE_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt >= CNT_W'(PULSE_LIMIT));

  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PULSE_LIMIT)); // R5
  AST_CNT_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R5
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R9

endmodule

// File: rtl/flsts_toggle.sv
module flsts_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic tog
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog <= 1'b0;
    else if (clr)  tog <= 1'b0;
    else if (flip) tog <= ~tog;
  end

  AST_TOG_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clr) |=> (tog != $past(tog))); // R3
  AST_TOG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && !clr) |=> $stable(tog)); // R3

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flsts_pkg::*;
#(
  parameter int unsigned PULSE_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_kind_i,
  input  logic [DATA_W-1:0] target_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic              tick_i,
  input  logic              pass_i,
  input  logic              rd_i,
  input  logic              rst_cmd_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              status_mode_o
);

  localparam int unsigned CNT_W = $clog2(PULSE_LIMIT + 2);

  flsts_state_e      state_q, state_d;
  flsts_op_e         op_q;
  logic [DATA_W-1:0] tgt_q, sto_q;
  logic [CNT_W-1:0]  cnt;
  logic              at_limit;
  logic              tog;

  // Named internal events
  logic ev_start, ev_verified, ev_tick_fail, ev_limit, ev_reset, ev_read;

  assign ev_start     = (state_q == ST_ARRAY) && start_i;
  assign ev_verified  = (state_q == ST_BUSY) && tick_i &&
                        pulse_verified(op_q, tgt_q, sto_q, pass_i);
  assign ev_tick_fail = (state_q == ST_BUSY) && tick_i && !ev_verified;
  assign ev_limit     = ev_tick_fail && at_limit;
  assign ev_reset     = (state_q == ST_FAIL) && rst_cmd_i;
  assign ev_read      = (state_q != ST_ARRAY) && rd_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARRAY: if (ev_start) state_d = ST_BUSY;
      ST_BUSY: begin
        if (ev_verified)   state_d = ST_ARRAY;
        else if (ev_limit) state_d = ST_FAIL;
      end
      ST_FAIL:  if (ev_reset) state_d = ST_ARRAY;
      default:  state_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARRAY;
      op_q    <= OP_PROGRAM;
      tgt_q   <= '0;
      sto_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        op_q  <= flsts_op_e'(op_kind_i);
        tgt_q <= target_i;
        sto_q <= stored_i;
      end
    end
  end

  flsts_pulse_ctr #(.PULSE_LIMIT(PULSE_LIMIT)) i_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ev_start),
    .inc      (ev_tick_fail && !at_limit),
    .cnt      (cnt),
    .at_limit (at_limit)
  );

  flsts_toggle i_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_start),
    .flip  (ev_read),
    .tog   (tog)
  );

  assign status_mode_o = (state_q != ST_ARRAY);
  assign dout_o = status_mode_o ? status_byte(tog, state_q == ST_FAIL) : array_i;

  AST_START_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (status_mode_o && dout_o == '0)); // R2
  AST_SUCCESS_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_verified |=> !status_mode_o); // R4
  AST_BLOCKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && op_q == OP_PROGRAM && prog_blocked(tgt_q, sto_q))
      |=> status_mode_o); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL && !rst_cmd_i) |=> (status_mode_o && dout_o[FAIL_BIT])); // R7
  AST_RESET_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reset |=> !status_mode_o); // R7
  AST_BUSY_IGNORES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !tick_i) |=> status_mode_o); // R8

endmodule

// File: tb/test_flash_op_status.sv
`timescale 1ns/1ps
module test_flash_op_status;

  localparam int unsigned LIM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, op_kind_i = 0, tick_i = 0, pass_i = 0, rd_i = 0, rst_cmd_i = 0;
  logic [7:0] target_i = '0, stored_i = '0, array_i = 8'hA5;
  logic [7:0] dout_o;
  logic       status_mode_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  flash_op_status #(.PULSE_LIMIT(LIM)) i_flash_op_status (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_kind_i(op_kind_i),
    .target_i(target_i), .stored_i(stored_i), .tick_i(tick_i), .pass_i(pass_i),
    .rd_i(rd_i), .rst_cmd_i(rst_cmd_i), .array_i(array_i),
    .dout_o(dout_o), .status_mode_o(status_mode_o)
  );

  function automatic logic [7:0] sts(input logic t, input logic f);
    return {1'b0, t, f, 5'b0};
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change only at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_op(input logic kind, input logic [7:0] t, input logic [7:0] s);
    op_kind_i = kind; target_i = t; stored_i = s; start_i = 1;
    step();
    start_i = 0;
  endtask

  task automatic pulse(input logic ok);
    tick_i = 1; pass_i = ok;
    step();
    tick_i = 0; pass_i = 0;
  endtask

  task automatic do_read();
    rd_i = 1;
    step();
    rd_i = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 mode", {1'b0, status_mode_o}, 9'd0);
    chk("R1 data", {1'b0, dout_o}, {1'b0, array_i});
  endtask

  task automatic t_array_mode();
    array_i = 8'h3C; do_read(); do_read();
    chk("R2 array follows", {status_mode_o, dout_o}, {1'b0, 8'h3C});
    array_i = 8'hC3; #1;
    chk("R2 array follows 2", {status_mode_o, dout_o}, {1'b0, 8'hC3});
    start_op(1'b1, 8'h00, 8'hFF);
    chk("R2 enter status", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
  endtask

  task automatic t_toggle();
    // continues the erase started in t_array_mode
    do_read();
    chk("R3 flip 1", {status_mode_o, dout_o}, {1'b1, sts(1, 0)});
    step(); step();
    chk("R3 hold", {status_mode_o, dout_o}, {1'b1, sts(1, 0)});
    do_read();
    chk("R3 flip 2", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
    rst_cmd_i = 1; step(); rst_cmd_i = 0;
    chk("R8 reset ignored busy", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
    do_read();
    start_op(1'b0, 8'hFF, 8'hFF);
    chk("R8 start ignored", {status_mode_o, dout_o}, {1'b1, sts(1, 0)});
    pulse(1'b1);
    array_i = 8'h5A; #1;
    chk("R4 erase done", {status_mode_o, dout_o}, {1'b0, 8'h5A});
    do_read();
    chk("R4 no toggle after", {status_mode_o, dout_o}, {1'b0, 8'h5A});
  endtask

  task automatic t_program_ok();
    start_op(1'b0, 8'h0F, 8'h3F);
    do_read();
    chk("R9 fresh toggle", {status_mode_o, dout_o}, {1'b1, sts(1, 0)});
    pulse(1'b0); pulse(1'b0);
    chk("R5 counting", {status_mode_o, dout_o}, {1'b1, sts(1, 0)});
    pulse(1'b1);
    chk("R4 program done", {status_mode_o, dout_o}, {1'b0, array_i});
  endtask

  task automatic t_limit();
    start_op(1'b1, 8'h00, 8'h00);
    for (int i = 0; i < LIM; i++) pulse(1'b0);
    chk("R5 at limit no fail", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
    pulse(1'b0);
    chk("R5 past limit fail", {status_mode_o, dout_o}, {1'b1, sts(0, 1)});
    do_read();
    chk("R7 toggles in fail", {status_mode_o, dout_o}, {1'b1, sts(1, 1)});
    pulse(1'b1);
    chk("R7 tick ignored", {status_mode_o, dout_o}, {1'b1, sts(1, 1)});
    do_read();
    chk("R7 toggles again", {status_mode_o, dout_o}, {1'b1, sts(0, 1)});
    rst_cmd_i = 1; step(); rst_cmd_i = 0;
    chk("R7 reset exits", {status_mode_o, dout_o}, {1'b0, array_i});
  endtask

  task automatic t_one_over_zero();
    start_op(1'b0, 8'h81, 8'h80);
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    chk("R6 no verify", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
    pulse(1'b1);
    chk("R6 ends failed", {status_mode_o, dout_o}, {1'b1, sts(0, 1)});
    step(); step();
    chk("R7 fail holds", {status_mode_o, dout_o}, {1'b1, sts(0, 1)});
    rst_cmd_i = 1; step(); rst_cmd_i = 0;
    chk("R7 back to array", {status_mode_o, dout_o}, {1'b0, array_i});
    // R9: count restarts after an earlier run reached the limit
    start_op(1'b1, 8'h00, 8'h00);
    for (int i = 0; i < LIM; i++) pulse(1'b0);
    chk("R9 count restarts", {status_mode_o, dout_o}, {1'b1, sts(0, 0)});
    pulse(1'b1);
    chk("R9 then completes", {1'b0, status_mode_o}, 9'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_array_mode();
    t_toggle();
    t_program_ok();
    t_limit();
    t_one_over_zero();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule